// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide programming interface of one eight-line priority interrupt controller. A host writes and reads bytes through a two-address window that is selected by a single address bit. Through this window it runs the initialization word sequence, issues operation commands (end-of-interrupt variants, priority rotation, register read selection, poll and special mask), and reads back the mask, request or in-service register.

The block holds the mask, in-service, rotation offset, base vector and mode registers. It receives the live request vector from the neighbouring resolver and can ask that resolver to clear request bits, either all at once when initialization starts or one at a time when a poll read consumes a request. A separate trigger-mode register is reached through its own select input. Writes to it pass through a fixed mask that depends on whether the instance is the master or the slave controller.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the mask, in-service, base vector, offset, mode and trigger-mode registers are all zero, and no initialization is in progress.
- R2: A command write to address 0 with bit 4 set starts initialization. In that cycle irr_clr_o is all ones. At the next edge the mask, in-service, offset, base vector and all mode bits are cleared, and init_active_o rises.
- R3: During initialization the next address-1 write stores the base vector with bits 2:0 forced to zero, and the address-1 write after it is ignored. If bit 0 of the start word was 1, a fourth address-1 write sets nested mode from bit 4 and auto-EOI from bit 1. Otherwise the third word ends the sequence.
- R4: An address-1 command write outside initialization loads the mask register. A non-poll read at address 1 returns the mask.
- R5: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a status command. If bit 1 is set, bit 0 selects what an address-0 read returns (1 = in-service, 0 = request). If bit 6 is set, bit 5 loads the special-mask flag. Bit 2 arms poll.
- R6: With bits 4:3 = 00, bits 7:5 form an operation code. Code 1 clears the highest-priority in-service bit, where priority starts at the line equal to the offset and goes up modulo 8. Code 5 does the same and also sets the offset to (cleared line + 1) mod 8. Neither code changes anything when no in-service bit is set.
- R7: Code 3 clears the in-service bit named by bits 2:0. Code 6 sets the offset to (bits 2:0 + 1) mod 8. Code 7 does both. Code 2 changes nothing.
- R8: Codes 0 and 4 load the rotate-on-auto-EOI flag from bit 7.
- R9: A read while poll is armed returns {5'b0, line}. The line is the highest-priority unmasked request, and it is returned only if it outranks the highest in-service line; otherwise the read returns 7. When a line is returned, irr_clr_o carries only that line's bit in the read cycle and the line's in-service bit is cleared. Poll then disarms.
- R10: On the master instance with nested mode set, in-service bit 2 is left out of the poll priority comparison.
- R11: With trig_sel_i high, a write stores wdata_i AND 0xF8 (master) or 0xDE (slave) into the trigger-mode register, and a read returns it.
- R12: rdata_o is valid in the same cycle as rd_en_i and is zero when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 1 | Address bit within the two-byte window |
| trig_sel_i | input | 1 | Selects the trigger-mode register instead of the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| irr_i | input | 8 | Request vector from the resolver |
| isr_set_i | input | 8 | In-service bits to set on acknowledge |
| irr_clr_o | output | 8 | Request bits for the resolver to clear |
| imr_o | output | 8 | Mask register |
| isr_o | output | 8 | In-service register |
| base_o | output | 8 | Base vector |
| offset_o | output | 3 | Priority rotation offset |
| nested_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| spec_mask_o | output | 1 | Special mask flag |
| trig_o | output | 8 | Trigger-mode register |
| init_active_o | output | 1 | Initialization sequence in progress |

## Verification
Initialization is run both with and without the fourth word. This shows whether the sequencer counts words correctly and whether a later address-1 write reaches the mask. End-of-interrupt codes are applied to in-service patterns at several rotation offsets, including an empty register. This separates rotation-aware priority from a fixed lowest-bit search, and specific clears from non-specific ones. Poll reads are tried with a request that wins, a request that an in-service line outranks, a masked request, and the master's nested case. Each of these yields a different returned line and a different clear pulse.

// File: rtl/pic_cfg_pkg.sv
package pic_cfg_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned LINE_W = 3;

  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_W3   = 2'd2,
    INIT_W4   = 2'd3
  } init_state_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR  = 3'd0,
    OP_EOI      = 3'd1,
    OP_NOP      = 3'd2,
    OP_EOI_SPEC = 3'd3,
    OP_ROT_SET  = 3'd4,
    OP_EOI_ROT  = 3'd5,
    OP_SET_PRIO = 3'd6,
    OP_SPEC_ROT = 3'd7
  } op_code_e;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] off_i,
  output logic         hit_o,
  output logic [W-1:0] line_o,
  output logic [W-1:0] rank_o
);
  // rank 0 is the line equal to the offset; lowest rank wins
  always_comb begin
    hit_o  = 1'b0;
    line_o = '0;
    rank_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [W-1:0] idx;
      idx = W'(k) + off_i;
      if (vec_i[idx]) begin
        hit_o  = 1'b1;
        line_o = idx;
        rank_o = W'(k);
      end
    end
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        need4_i,
  input  logic        data_wr_i,
  output init_state_e state_o,
  output logic        mask_we_o,
  output logic        base_we_o,
  output logic        mode_we_o
);
  init_state_e state_q;
  logic        need4_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INIT_IDLE;
      need4_q <= 1'b0;
    end else if (start_i) begin
      state_q <= INIT_BASE;
      need4_q <= need4_i;
    end else if (data_wr_i) begin
      unique case (state_q)
        INIT_IDLE: state_q <= INIT_IDLE;
        INIT_BASE: state_q <= INIT_W3;
        INIT_W3:   state_q <= need4_q ? INIT_W4 : INIT_IDLE;
        INIT_W4:   state_q <= INIT_IDLE;
        default:   state_q <= INIT_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign mask_we_o = data_wr_i && !start_i && (state_q == INIT_IDLE);
  assign base_we_o = data_wr_i && !start_i && (state_q == INIT_BASE);
  assign mode_we_o = data_wr_i && !start_i && (state_q == INIT_W4);
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cfg_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int unsigned CASCADE_LINE = 2,
  localparam int unsigned N = LINES,
  localparam int unsigned W = LINE_W,
  localparam logic [7:0] TRIG_MASK = IS_MASTER ? 8'hF8 : 8'hDE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic         addr_i,
  input  logic         trig_sel_i,
  input  logic [7:0]   wdata_i,
  output logic [7:0]   rdata_o,
  input  logic [N-1:0] irr_i,
  input  logic [N-1:0] isr_set_i,
  output logic [N-1:0] irr_clr_o,
  output logic [N-1:0] imr_o,
  output logic [N-1:0] isr_o,
  output logic [7:0]   base_o,
  output logic [W-1:0] offset_o,
  output logic         nested_o,
  output logic         auto_eoi_o,
  output logic         rot_aeoi_o,
  output logic         spec_mask_o,
  output logic [7:0]   trig_o,
  output logic         init_active_o
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_LINE;

  logic [N-1:0] imr_q, isr_q;
  logic [7:0]   base_q, trig_q;
  logic [W-1:0] off_q;
  logic         nested_q, aeoi_q, rot_q, smask_q, rsel_q, poll_q;

  // decode
  logic win_wr, w0, w1, start, stat_cmd, op_cmd, poll_rd;
  op_code_e op;
  assign win_wr   = wr_en_i && !trig_sel_i;
  assign w0       = win_wr && !addr_i;
  assign w1       = win_wr && addr_i;
  assign start    = w0 && wdata_i[4];
  assign stat_cmd = w0 && !wdata_i[4] && wdata_i[3];
  assign op_cmd   = w0 && !wdata_i[4] && !wdata_i[3];
  assign op       = op_code_e'(wdata_i[7:5]);
  assign poll_rd  = rd_en_i && !trig_sel_i && poll_q;

  init_state_e istate;
  logic mask_we, base_we, mode_we;

  pic_init_fsm u_init (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .need4_i  (wdata_i[0]),
    .data_wr_i(w1),
    .state_o  (istate),
    .mask_we_o(mask_we),
    .base_we_o(base_we),
    .mode_we_o(mode_we)
  );

  // priority pickers
  logic [N-1:0] req_vec, isr_nest_vec;
  logic         req_hit, nest_hit, eoi_hit;
  logic [W-1:0] req_line, req_rank, nest_line, nest_rank, eoi_line, eoi_rank;

  assign req_vec      = irr_i & ~imr_q;
  assign isr_nest_vec = (IS_MASTER && nested_q) ? (isr_q & ~CASC_BIT) : isr_q;

  pic_prio_pick #(.N(N)) u_req_pick (
    .vec_i(req_vec), .off_i(off_q), .hit_o(req_hit), .line_o(req_line), .rank_o(req_rank)
  );
  pic_prio_pick #(.N(N)) u_nest_pick (
    .vec_i(isr_nest_vec), .off_i(off_q), .hit_o(nest_hit), .line_o(nest_line), .rank_o(nest_rank)
  );
  pic_prio_pick #(.N(N)) u_eoi_pick (
    .vec_i(isr_q), .off_i(off_q), .hit_o(eoi_hit), .line_o(eoi_line), .rank_o(eoi_rank)
  );

  logic poll_win;
  assign poll_win = req_hit && (!nest_hit || (req_rank < nest_rank));

  // operation commands
  logic [N-1:0] op_clr;
  logic         off_ld, rot_ld;
  logic [W-1:0] off_val;
  logic [W-1:0] arg_line;
  assign arg_line = wdata_i[W-1:0];

  always_comb begin
    op_clr  = '0;
    off_ld  = 1'b0;
    off_val = off_q;
    rot_ld  = 1'b0;
    if (op_cmd) begin
      unique case (op)
        OP_ROT_CLR, OP_ROT_SET: rot_ld = 1'b1;
        OP_EOI: if (eoi_hit) op_clr[eoi_line] = 1'b1;
        OP_EOI_ROT: if (eoi_hit) begin
          op_clr[eoi_line] = 1'b1;
          off_ld  = 1'b1;
          off_val = eoi_line + W'(1);
        end
        OP_EOI_SPEC: op_clr[arg_line] = 1'b1;
        OP_SET_PRIO: begin
          off_ld  = 1'b1;
          off_val = arg_line + W'(1);
        end
        OP_SPEC_ROT: begin
          op_clr[arg_line] = 1'b1;
          off_ld  = 1'b1;
          off_val = arg_line + W'(1);
        end
        default: ;
      endcase
    end
  end

  logic [N-1:0] poll_clr;
  always_comb begin
    poll_clr = '0;
    if (poll_rd && poll_win) poll_clr[req_line] = 1'b1;
  end

  assign irr_clr_o = start ? '1 : poll_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q    <= '0;
      isr_q    <= '0;
      base_q   <= '0;
      off_q    <= '0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      rot_q    <= 1'b0;
      smask_q  <= 1'b0;
      rsel_q   <= 1'b0;
      poll_q   <= 1'b0;
    end else if (start) begin
      imr_q    <= '0;
      isr_q    <= '0;
      base_q   <= '0;
      off_q    <= '0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      rot_q    <= 1'b0;
      smask_q  <= 1'b0;
      rsel_q   <= 1'b0;
      poll_q   <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~op_clr & ~poll_clr) | isr_set_i;
      if (mask_we) imr_q <= wdata_i;
      if (base_we) base_q <= {wdata_i[7:3], 3'b000};
      if (mode_we) begin
        nested_q <= wdata_i[4];
        aeoi_q   <= wdata_i[1];
      end
      if (off_ld) off_q <= off_val;
      if (rot_ld) rot_q <= wdata_i[7];
      if (stat_cmd && wdata_i[1]) rsel_q  <= wdata_i[0];
      if (stat_cmd && wdata_i[6]) smask_q <= wdata_i[5];
      if (stat_cmd && wdata_i[2]) poll_q <= 1'b1;
      else if (poll_rd)           poll_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   trig_q <= '0;
    else if (wr_en_i && trig_sel_i) trig_q <= wdata_i & TRIG_MASK;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (trig_sel_i)  rdata_o = trig_q;
      else if (poll_q) rdata_o = poll_win ? {{(8 - W){1'b0}}, req_line} : 8'd7;
      else if (addr_i) rdata_o = imr_q;
      else             rdata_o = rsel_q ? isr_q : irr_i;
    end
  end

  assign imr_o         = imr_q;
  assign isr_o         = isr_q;
  assign base_o        = base_q;
  assign offset_o      = off_q;
  assign nested_o      = nested_q;
  assign auto_eoi_o    = aeoi_q;
  assign rot_aeoi_o    = rot_q;
  assign spec_mask_o   = smask_q;
  assign trig_o        = trig_q;
  assign init_active_o = (istate != INIT_IDLE);
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk #(
  parameter bit IS_MASTER = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic       addr_i,
  input logic       trig_sel_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [7:0] irr_clr_o,
  input logic [7:0] imr_o,
  input logic [7:0] isr_o,
  input logic [7:0] base_o,
  input logic [2:0] offset_o,
  input logic       auto_eoi_o,
  input logic [7:0] trig_o,
  input logic       init_active_o
);
  localparam logic [7:0] TMASK = IS_MASTER ? 8'hF8 : 8'hDE;

  logic init_wr;
  assign init_wr = wr_en_i && !trig_sel_i && !addr_i && wdata_i[4];

  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr |=> (imr_o == 8'h00 && isr_o == 8'h00 && base_o == 8'h00 && offset_o == 3'd0
                 && !auto_eoi_o && init_active_o)); // R2
  AST_INIT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr |-> irr_clr_o == 8'hFF); // R2
  AST_BASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[2:0] == 3'b000); // R3
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !trig_sel_i && addr_i && !init_active_o) |=> imr_o == $past(wdata_i)); // R4
  AST_POLL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_wr |-> $onehot0(irr_clr_o)); // R9
  AST_TRIG_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o & ~TMASK) == 8'h00); // R11
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 8'h00); // R12
endmodule

bind pic_cmd_port pic_cmd_port_chk #(.IS_MASTER(IS_MASTER)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .addr_i       (addr_i),
  .trig_sel_i   (trig_sel_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .irr_clr_o    (irr_clr_o),
  .imr_o        (imr_o),
  .isr_o        (isr_o),
  .base_o       (base_o),
  .offset_o     (offset_o),
  .auto_eoi_o   (auto_eoi_o),
  .trig_o       (trig_o),
  .init_active_o(init_active_o)
);

// File: tb/pic_cmd_port_test.sv
`timescale 1ns/1ps
module pic_cmd_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, trig_sel = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr_set = '0;
  logic [7:0] rdata, irr_clr, imr, isr, base, trig;
  logic [2:0] offset;
  logic       nested, aeoi, rot, smask, init_act;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pic_cmd_port #(.IS_MASTER(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .trig_sel_i(trig_sel), .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr),
    .isr_set_i(isr_set), .irr_clr_o(irr_clr), .imr_o(imr), .isr_o(isr), .base_o(base),
    .offset_o(offset), .nested_o(nested), .auto_eoi_o(aeoi), .rot_aeoi_o(rot),
    .spec_mask_o(smask), .trig_o(trig), .init_active_o(init_act)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ts, input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; trig_sel = ts; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; trig_sel = 1'b0;
  endtask

  task automatic rd(input logic ts, input logic a, output logic [7:0] d, output logic [7:0] clr);
    @(negedge clk);
    rd_en = 1'b1; trig_sel = ts; addr = a;
    #1;
    d = rdata; clr = irr_clr;
    @(negedge clk);
    rd_en = 1'b0; trig_sel = 1'b0;
  endtask

  task automatic set_isr(input logic [7:0] v);
    @(negedge clk);
    isr_set = v;
    @(negedge clk);
    isr_set = '0;
  endtask

  task automatic t_reset;
    check("R1 imr", imr, 8'h00);
    check("R1 isr", isr, 8'h00);
    check("R1 base", base, 8'h00);
    check("R1 modes", {offset, nested, aeoi, rot, smask, init_act}, 8'h00);
    check("R1 trig", trig, 8'h00);
  endtask

  task automatic t_init_full;
    logic [7:0] d, c;
    wr(0, 1, 8'hAA);
    check("R4 mask load", imr, 8'hAA);
    rd(0, 1, d, c);
    check("R4 mask read", d, 8'hAA);
    set_isr(8'h0F);
    @(negedge clk);
    wr_en = 1'b1; addr = 1'b0; wdata = 8'h11;
    #1 check("R2 request flush", irr_clr, 8'hFF);
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 mask cleared", imr, 8'h00);
    check("R2 isr cleared", isr, 8'h00);
    check("R2 init active", {7'd0, init_act}, 8'h01);
    wr(0, 1, 8'h47);
    check("R3 base aligned", base, 8'h40);
    wr(0, 1, 8'h55);
    check("R3 third word ignored", imr, 8'h00);
    wr(0, 1, 8'h12);
    check("R3 modes from fourth word", {5'd0, nested, aeoi, init_act}, 8'h06);
    wr(0, 1, 8'h3C);
    check("R4 mask after init", imr, 8'h3C);
  endtask

  task automatic t_init_short;
    wr(0, 0, 8'h10);
    wr(0, 1, 8'h08);
    check("R3 base short", base, 8'h08);
    wr(0, 1, 8'hFF);
    check("R3 short ends", {6'd0, nested, init_act}, 8'h00);
    check("R3 short mask untouched", imr, 8'h00);
    wr(0, 1, 8'h81);
    check("R4 mask after short init", imr, 8'h81);
  endtask

  task automatic t_status;
    logic [7:0] d, c;
    irr = 8'h24;
    wr(0, 0, 8'h0A);
    rd(0, 0, d, c);
    check("R5 read request", d, 8'h24);
    set_isr(8'h11);
    wr(0, 0, 8'h0B);
    rd(0, 0, d, c);
    check("R5 read in-service", d, 8'h11);
    wr(0, 0, 8'h08);
    rd(0, 0, d, c);
    check("R5 select held", d, 8'h11);
    wr(0, 0, 8'h68);
    check("R5 special mask set", {7'd0, smask}, 8'h01);
    wr(0, 0, 8'h48);
    check("R5 special mask clear", {7'd0, smask}, 8'h00);
    @(negedge clk);
    check("R12 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_eoi;
    wr(0, 0, 8'h20);
    check("R6 eoi lowest", isr, 8'h10);
    wr(0, 0, 8'hC5);
    check("R7 set priority", {5'd0, offset}, 8'h06);
    set_isr(8'h81);
    wr(0, 0, 8'h20);
    check("R6 eoi rotated", isr, 8'h11);
    wr(0, 0, 8'hA0);
    check("R6 eoi rotate isr", isr, 8'h10);
    check("R6 eoi rotate offset", {5'd0, offset}, 8'h01);
    wr(0, 0, 8'h64);
    check("R7 specific eoi", isr, 8'h00);
    set_isr(8'h04);
    wr(0, 0, 8'hE2);
    check("R7 specific rotate isr", isr, 8'h00);
    check("R7 specific rotate offset", {5'd0, offset}, 8'h03);
    set_isr(8'h08);
    wr(0, 0, 8'h47);
    check("R7 nop isr", isr, 8'h08);
    check("R7 nop offset", {5'd0, offset}, 8'h03);
    wr(0, 0, 8'h63);
    wr(0, 0, 8'hA0);
    check("R6 empty eoi keeps offset", {5'd0, offset}, 8'h03);
    wr(0, 0, 8'h80);
    check("R8 rotate flag set", {7'd0, rot}, 8'h01);
    wr(0, 0, 8'h00);
    check("R8 rotate flag clear", {7'd0, rot}, 8'h00);
  endtask

  task automatic t_poll;
    logic [7:0] d, c;
    wr(0, 0, 8'hC7);
    wr(0, 1, 8'h00);
    irr = 8'h24;
    wr(0, 0, 8'h0C);
    rd(0, 0, d, c);
    check("R9 poll winner", d, 8'h02);
    check("R9 poll clear", c, 8'h04);
    rd(0, 0, d, c);
    check("R9 poll disarmed", d, 8'h00);
    set_isr(8'h01);
    wr(0, 0, 8'h0C);
    rd(0, 0, d, c);
    check("R9 poll outranked", d, 8'h07);
    check("R9 poll no clear", c, 8'h00);
    wr(0, 0, 8'h60);
    wr(0, 1, 8'h04);
    wr(0, 0, 8'h0C);
    rd(0, 0, d, c);
    check("R9 poll masked", d, 8'h05);
    check("R9 poll masked clear", c, 8'h20);
  endtask

  task automatic t_nested;
    logic [7:0] d, c;
    wr(0, 0, 8'h11);
    wr(0, 1, 8'h00);
    wr(0, 1, 8'h00);
    wr(0, 1, 8'h10);
    check("R10 nested set", {7'd0, nested}, 8'h01);
    set_isr(8'h04);
    irr = 8'h08;
    wr(0, 0, 8'h0C);
    rd(0, 1, d, c);
    check("R10 cascade ignored", d, 8'h03);
    check("R10 isr kept", isr, 8'h04);
    irr = 8'h04;
    wr(0, 0, 8'h0C);
    rd(0, 0, d, c);
    check("R10 cascade request", d, 8'h02);
    check("R9 poll clears in-service", isr, 8'h00);
  endtask

  task automatic t_trig;
    logic [7:0] d, c;
    wr(1, 0, 8'hFF);
    rd(1, 0, d, c);
    check("R11 trigger masked", d, 8'hF8);
    check("R11 window untouched", imr, 8'h00);
    wr(1, 1, 8'h07);
    check("R11 trigger low bits", trig, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_init_short();
    t_status();
    t_eoi();
    t_poll();
    t_nested();
    t_trig();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule